// File: doc/BRIEF.md
# Integer Decode and Execute Unit

A purely combinational stage for a 32-bit load/store core with 32 general registers. It takes one 32-bit instruction word and the two register values the register file read for it, and returns which register to write, whether to write it, the value to write, and three side flags: a halt request, an illegal-opcode flag and a divide-by-zero flag.

Two operand forms exist. In the register form both operands come from registers. In the immediate form the second operand is a 16-bit constant, which the unit widens one of several ways depending on the operation. The unit covers add and subtract, the five bitwise operations and two upper-half immediate variants, six compares, three shifts, byte and halfword sign extension, multiply, and unsigned divide and remainder. The surrounding pipeline owns fetch, memory, branches and timing. It feeds a new word in each cycle and samples the outputs before the next edge.

Top module: `dxu_top`

## Requirements
- R1: Bit 31 set selects the register form, clear selects the immediate form. The opcode is bits 30..26. The first source index is bits 25..21. The second source index is bits 20..16 in both forms. `dstIdx` is bits 15..11 in register form and bits 20..16 in immediate form, whatever the opcode.
- R2: Opcode 0 adds and opcode 1 subtracts (first minus second), both modulo 2^32. The add immediate is sign-extended. Subtract exists only in register form.
- R3: Opcodes 2, 3, 4, 5 and 6 are AND, OR, XOR, NOR and XNOR. Their 16-bit immediate is zero-extended.
- R4: Opcodes 7 and 8 are AND and OR with the immediate placed in bits 31..16 and zeros below. They exist only in immediate form.
- R5: Opcodes 9 to 14 compare the first operand with the second and write 1 if the condition holds, else 0. In order, the conditions are equal, not equal, signed greater, signed greater-or-equal, unsigned greater and unsigned greater-or-equal. The compare immediate is sign-extended.
- R6: Opcodes 15, 16 and 17 are shift left, arithmetic shift right and logical shift right. Only the low 5 bits of the amount are used. In immediate form the amount is instruction bits 4..0.
- R7: Opcodes 18 and 19 copy bit 7 (byte) or bit 15 (halfword) of the first operand into all higher bits. They exist only in register form.
- R8: Opcode 20 gives the low 32 bits of the product. Its immediate is sign-extended.
- R9: Opcodes 21 and 22 are unsigned quotient and remainder, register form only. A zero divisor raises `divZero` and clears `wrEn`.
- R10: A register-form AND (opcode 2) whose three register fields are all zero raises `haltReq` and clears `wrEn`. The same fields in immediate form do not halt.
- R11: A source field of 0 reads as zero whatever the input value. `wrEn` is never set when `dstIdx` is 0.
- R12: Every other opcode/form combination raises `illegalOp` and clears `wrEn` and `haltReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| srcA | input | 32 | Value of the register named by bits 25..21 |
| srcB | input | 32 | Value of the register named by bits 20..16 |
| dstIdx | output | 5 | Destination register index |
| wrEn | output | 1 | Write the result to `dstIdx` |
| result | output | 32 | Computed value |
| haltReq | output | 1 | Halt encoding seen |
| illegalOp | output | 1 | Unsupported opcode/form |
| divZero | output | 1 | Divide or remainder by zero |

## Verification
The bench targets the places where the extension rule changes between neighbouring opcodes. A design that sign-extends a logic immediate would fill the upper half with ones. One that zero-extends a compare immediate would get the signed and unsigned greater-or-equal results wrong for all-ones constants. It also drives shift amounts with high bits set and an amount of exactly 32, which a design that does not mask would turn into zero or an all-sign result. It covers a zero divisor, which must block the write and not produce a stale quotient, and the halt encoding next to nearly identical ANDs that must still write. A sweep of all 64 opcode/form pairs catches a decoder that accepts a form with no defined meaning, such as a register-form upper-half AND, or that rejects a valid one.

// File: rtl/dxu_pkg.sv
package dxu_pkg;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR, ALU_XNOR, ALU_CMP,
    ALU_SL, ALU_SR, ALU_SRU, ALU_SEXTB, ALU_SEXTH, ALU_MUL, ALU_DIV, ALU_MOD
  } aluOp_e;

  typedef enum logic [2:0] {
    CMP_EQ, CMP_NE, CMP_GT, CMP_GE, CMP_GTU, CMP_GEU
  } cmpSel_e;

  typedef enum logic [1:0] {
    IMM_SEXT, IMM_ZEXT, IMM_HIGH, IMM_SHAMT
  } immKind_e;

  // strobes from control to datapath
  typedef struct packed {
    aluOp_e      aluOp;
    cmpSel_e     cmpSel;
    logic        useImm;
    immKind_e    immKind;
    logic [4:0]  aIdx;
    logic [4:0]  bIdx;
    logic [15:0] imm16;
  } aluCtrl_t;

endpackage

// File: rtl/dxu_control.sv
module dxu_control
  import dxu_pkg::*;
(
  input  logic [31:0] instr,
  output aluCtrl_t    aluCtrl,
  output logic [4:0]  dstIdx,
  output logic        writeReq,
  output logic        haltReq,
  output logic        illegal
);

  logic       isRR;
  logic [4:0] code;
  logic       legal;
  logic       zeroFields;

  assign isRR       = instr[31];
  assign code       = instr[30:26];
  assign zeroFields = (instr[25:11] == 15'd0);

  always_comb begin
    aluCtrl.aluOp   = ALU_ADD;
    aluCtrl.cmpSel  = CMP_EQ;
    aluCtrl.useImm  = ~isRR;
    aluCtrl.immKind = IMM_SEXT;
    aluCtrl.aIdx    = instr[25:21];
    aluCtrl.bIdx    = instr[20:16];
    aluCtrl.imm16   = instr[15:0];
    dstIdx          = isRR ? instr[15:11] : instr[20:16];
    legal           = 1'b1;
    haltReq         = 1'b0;

    case (code)
      5'd0:  aluCtrl.aluOp = ALU_ADD;
      5'd1:  begin aluCtrl.aluOp = ALU_SUB; legal = isRR; end
      5'd2:  begin
               aluCtrl.aluOp = ALU_AND; aluCtrl.immKind = IMM_ZEXT;
               haltReq = isRR & zeroFields;
             end
      5'd3:  begin aluCtrl.aluOp = ALU_OR;   aluCtrl.immKind = IMM_ZEXT; end
      5'd4:  begin aluCtrl.aluOp = ALU_XOR;  aluCtrl.immKind = IMM_ZEXT; end
      5'd5:  begin aluCtrl.aluOp = ALU_NOR;  aluCtrl.immKind = IMM_ZEXT; end
      5'd6:  begin aluCtrl.aluOp = ALU_XNOR; aluCtrl.immKind = IMM_ZEXT; end
      5'd7:  begin aluCtrl.aluOp = ALU_AND; aluCtrl.immKind = IMM_HIGH; legal = ~isRR; end
      5'd8:  begin aluCtrl.aluOp = ALU_OR;  aluCtrl.immKind = IMM_HIGH; legal = ~isRR; end
      5'd9:  begin aluCtrl.aluOp = ALU_CMP; aluCtrl.cmpSel = CMP_EQ;  end
      5'd10: begin aluCtrl.aluOp = ALU_CMP; aluCtrl.cmpSel = CMP_NE;  end
      5'd11: begin aluCtrl.aluOp = ALU_CMP; aluCtrl.cmpSel = CMP_GT;  end
      5'd12: begin aluCtrl.aluOp = ALU_CMP; aluCtrl.cmpSel = CMP_GE;  end
      5'd13: begin aluCtrl.aluOp = ALU_CMP; aluCtrl.cmpSel = CMP_GTU; end
      5'd14: begin aluCtrl.aluOp = ALU_CMP; aluCtrl.cmpSel = CMP_GEU; end
      5'd15: begin aluCtrl.aluOp = ALU_SL;  aluCtrl.immKind = IMM_SHAMT; end
      5'd16: begin aluCtrl.aluOp = ALU_SR;  aluCtrl.immKind = IMM_SHAMT; end
      5'd17: begin aluCtrl.aluOp = ALU_SRU; aluCtrl.immKind = IMM_SHAMT; end
      5'd18: begin aluCtrl.aluOp = ALU_SEXTB; legal = isRR; end
      5'd19: begin aluCtrl.aluOp = ALU_SEXTH; legal = isRR; end
      5'd20: aluCtrl.aluOp = ALU_MUL;
      5'd21: begin aluCtrl.aluOp = ALU_DIV; legal = isRR; end
      5'd22: begin aluCtrl.aluOp = ALU_MOD; legal = isRR; end
      default: legal = 1'b0;
    endcase

    if (!legal) haltReq = 1'b0;
  end

  assign illegal  = ~legal;
  assign writeReq = legal & ~haltReq;

  always_comb begin
    // R10 R12
    ctl_excl_chk: assert ($onehot0({writeReq, haltReq, illegal}))
      else $error("control strobes overlap");
  end

endmodule

// File: rtl/dxu_datapath.sv
module dxu_datapath
  import dxu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  aluCtrl_t           aluCtrl,
  input  logic [DATA_W-1:0]  srcA,
  input  logic [DATA_W-1:0]  srcB,
  output logic [DATA_W-1:0]  result,
  output logic               divZero
);

  localparam int SHW    = $clog2(DATA_W);
  localparam int IMM_W  = 16;
  localparam int PAD_W  = DATA_W - IMM_W;

  logic [DATA_W-1:0] opA, regB, immVal, opB, mulLow;
  logic [SHW-1:0]    shamt;
  logic              cmpHit, isDivOp;

  // register 0 reads as zero
  assign opA  = (aluCtrl.aIdx == 5'd0) ? '0 : srcA;
  assign regB = (aluCtrl.bIdx == 5'd0) ? '0 : srcB;

  always_comb begin
    unique case (aluCtrl.immKind)
      IMM_SEXT:  immVal = {{PAD_W{aluCtrl.imm16[IMM_W-1]}}, aluCtrl.imm16};
      IMM_ZEXT:  immVal = {{PAD_W{1'b0}}, aluCtrl.imm16};
      IMM_HIGH:  immVal = {aluCtrl.imm16, {PAD_W{1'b0}}};
      default:   immVal = {{(DATA_W-SHW){1'b0}}, aluCtrl.imm16[SHW-1:0]};
    endcase
  end

  assign opB     = aluCtrl.useImm ? immVal : regB;
  assign shamt   = opB[SHW-1:0];
  assign mulLow  = opA * opB;
  assign isDivOp = (aluCtrl.aluOp == ALU_DIV) || (aluCtrl.aluOp == ALU_MOD);
  assign divZero = isDivOp && (opB == '0);

  always_comb begin
    unique case (aluCtrl.cmpSel)
      CMP_EQ:  cmpHit = (opA == opB);
      CMP_NE:  cmpHit = (opA != opB);
      CMP_GT:  cmpHit = ($signed(opA) >  $signed(opB));
      CMP_GE:  cmpHit = ($signed(opA) >= $signed(opB));
      CMP_GTU: cmpHit = (opA >  opB);
      CMP_GEU: cmpHit = (opA >= opB);
      default: cmpHit = 1'b0;
    endcase
  end

  always_comb begin
    unique case (aluCtrl.aluOp)
      ALU_ADD:   result = opA + opB;
      ALU_SUB:   result = opA - opB;
      ALU_AND:   result = opA & opB;
      ALU_OR:    result = opA | opB;
      ALU_XOR:   result = opA ^ opB;
      ALU_NOR:   result = ~(opA | opB);
      ALU_XNOR:  result = ~(opA ^ opB);
      ALU_CMP:   result = {{(DATA_W-1){1'b0}}, cmpHit};
      ALU_SL:    result = opA << shamt;
      ALU_SR:    result = DATA_W'($signed(opA) >>> shamt);
      ALU_SRU:   result = opA >> shamt;
      ALU_SEXTB: result = {{(DATA_W-8){opA[7]}}, opA[7:0]};
      ALU_SEXTH: result = {{(DATA_W-16){opA[15]}}, opA[15:0]};
      ALU_MUL:   result = mulLow;
      ALU_DIV:   result = divZero ? '0 : opA / opB;
      ALU_MOD:   result = divZero ? '0 : opA % opB;
      default:   result = '0;
    endcase
  end

  always_comb begin
    // R5
    cmp_bool_chk: assert (aluCtrl.aluOp != ALU_CMP || result[DATA_W-1:1] == '0)
      else $error("compare result not boolean");
    // R6
    sru_fill_chk: assert (aluCtrl.aluOp != ALU_SRU || shamt == '0 || !result[DATA_W-1])
      else $error("logical right shift filled a one");
    // R7
    sext_fill_chk: assert (aluCtrl.aluOp != ALU_SEXTB ||
                           result[DATA_W-1:7] == '0 || result[DATA_W-1:7] == '1)
      else $error("byte extension upper bits not uniform");
  end

endmodule

// File: rtl/dxu_top.sv
module dxu_top
  import dxu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [31:0]        instr,
  input  logic [DATA_W-1:0]  srcA,
  input  logic [DATA_W-1:0]  srcB,
  output logic [4:0]         dstIdx,
  output logic               wrEn,
  output logic [DATA_W-1:0]  result,
  output logic               haltReq,
  output logic               illegalOp,
  output logic               divZero
);

  aluCtrl_t aluCtrl;
  logic     writeReq;

  dxu_control u_ctl (
    .instr    (instr),
    .aluCtrl  (aluCtrl),
    .dstIdx   (dstIdx),
    .writeReq (writeReq),
    .haltReq  (haltReq),
    .illegal  (illegalOp)
  );

  dxu_datapath #(.DATA_W(DATA_W)) u_dp (
    .aluCtrl (aluCtrl),
    .srcA    (srcA),
    .srcB    (srcB),
    .result  (result),
    .divZero (divZero)
  );

  assign wrEn = writeReq & ~divZero & (dstIdx != 5'd0);

  always_comb begin
    // R9
    div_nowrite_chk: assert (!(divZero && wrEn))
      else $error("write on zero divisor");
    // R11
    zero_dst_chk: assert (!(wrEn && dstIdx == 5'd0))
      else $error("write to register zero");
    // R12
    illegal_quiet_chk: assert (!(illegalOp && (wrEn || haltReq)))
      else $error("illegal opcode had side effect");
  end

endmodule

// File: tb/tb_dxu_top.sv
module tb_dxu_top;

  typedef struct packed {
    logic [3:0]  req;
    logic [31:0] instr;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic [4:0]  dst;
    logic        wen;
    logic        halt;
    logic        ill;
    logic        dz;
    logic        chkRes;
  } vec_t;

  function automatic logic [31:0] rr(input int op, input int ra, input int rb, input int rd);
    return {1'b1, 5'(op), 5'(ra), 5'(rb), 5'(rd), 11'd0};
  endfunction

  function automatic logic [31:0] ri(input int op, input int ra, input int rd, input logic [15:0] imm);
    return {1'b0, 5'(op), 5'(ra), 5'(rd), imm};
  endfunction

  function automatic vec_t mk(input int rq, input logic [31:0] ins, input logic [31:0] va,
                              input logic [31:0] vb, input logic [31:0] r, input int d,
                              input logic w, input logic h, input logic il, input logic z,
                              input logic c);
    return '{req: 4'(rq), instr: ins, a: va, b: vb, res: r, dst: 5'(d),
             wen: w, halt: h, ill: il, dz: z, chkRes: c};
  endfunction

  localparam int NV = 38;
  localparam vec_t VECS [NV] = '{
    mk(2,  rr(0,1,2,3),     32'd5, 32'd7, 32'd12, 3, 1,0,0,0,1),               // R2 add
    mk(2,  rr(1,1,2,3),     32'd5, 32'd7, 32'hFFFFFFFE, 3, 1,0,0,0,1),         // R2 sub
    mk(2,  ri(0,1,4,16'hFFFF), 32'd10, 32'd0, 32'd9, 4, 1,0,0,0,1),            // R2 addi sext
    mk(3,  ri(2,1,4,16'hFFFF), 32'h1234ABCD, 32'd0, 32'h0000ABCD, 4, 1,0,0,0,1), // R3
    mk(3,  ri(3,1,4,16'h8000), 32'h10000000, 32'd0, 32'h10008000, 4, 1,0,0,0,1), // R3
    mk(3,  rr(4,1,2,3), 32'hF0F0F0F0, 32'hFF00FF00, 32'h0FF00FF0, 3, 1,0,0,0,1), // R3 xor
    mk(3,  rr(5,1,2,3), 32'hF0F0F0F0, 32'h0F0F0000, 32'h00000F0F, 3, 1,0,0,0,1), // R3 nor
    mk(3,  ri(6,1,4,16'h00FF), 32'h000000F0, 32'd0, 32'hFFFFFFF0, 4, 1,0,0,0,1), // R3 xnori
    mk(4,  ri(7,1,4,16'hFF00), 32'h12345678, 32'd0, 32'h12000000, 4, 1,0,0,0,1), // R4
    mk(4,  ri(8,1,4,16'hABCD), 32'h00001111, 32'd0, 32'hABCD1111, 4, 1,0,0,0,1), // R4
    mk(5,  rr(9,1,2,3),  32'd7, 32'd7, 32'd1, 3, 1,0,0,0,1),                   // R5 eq
    mk(5,  rr(10,1,2,3), 32'd7, 32'd7, 32'd0, 3, 1,0,0,0,1),                   // R5 ne
    mk(5,  rr(11,1,2,3), 32'hFFFFFFFF, 32'd1, 32'd0, 3, 1,0,0,0,1),            // R5 gt signed
    mk(5,  rr(13,1,2,3), 32'hFFFFFFFF, 32'd1, 32'd1, 3, 1,0,0,0,1),            // R5 gtu
    mk(5,  ri(12,1,4,16'hFFFF), 32'hFFFFFFFF, 32'd0, 32'd1, 4, 1,0,0,0,1),     // R5 gei
    mk(5,  ri(14,1,4,16'hFFFF), 32'hFFFFFFFE, 32'd0, 32'd0, 4, 1,0,0,0,1),     // R5 geui
    mk(6,  rr(15,1,2,3), 32'd1, 32'h24, 32'h10, 3, 1,0,0,0,1),                 // R6 sl masked
    mk(6,  rr(16,1,2,3), 32'h80000000, 32'h1F, 32'hFFFFFFFF, 3, 1,0,0,0,1),    // R6 sr
    mk(6,  ri(17,1,4,16'hFFE4), 32'h80000000, 32'd0, 32'h08000000, 4, 1,0,0,0,1), // R6 srui
    mk(6,  rr(16,1,2,3), 32'h80000000, 32'h20, 32'h80000000, 3, 1,0,0,0,1),    // R6 amount 32
    mk(7,  rr(18,1,2,3), 32'h00000080, 32'd0, 32'hFFFFFF80, 3, 1,0,0,0,1),     // R7 byte
    mk(7,  rr(19,1,2,3), 32'hFFFF7FFF, 32'd0, 32'h00007FFF, 3, 1,0,0,0,1),     // R7 half
    mk(8,  rr(20,1,2,3), 32'h00010001, 32'h00010001, 32'h00020001, 3, 1,0,0,0,1), // R8
    mk(8,  ri(20,1,4,16'hFFFE), 32'd3, 32'd0, 32'hFFFFFFFA, 4, 1,0,0,0,1),     // R8 muli
    mk(9,  rr(21,1,2,3), 32'd100, 32'd7, 32'd14, 3, 1,0,0,0,1),                // R9 div
    mk(9,  rr(22,1,2,3), 32'd100, 32'd7, 32'd2, 3, 1,0,0,0,1),                 // R9 mod
    mk(9,  rr(21,1,2,3), 32'd5, 32'd0, 32'd0, 3, 0,0,0,1,0),                   // R9 div zero
    mk(9,  rr(22,1,2,3), 32'd5, 32'd0, 32'd0, 3, 0,0,0,1,0),                   // R9 mod zero
    mk(10, 32'h88000000, 32'd1, 32'd1, 32'd0, 0, 0,1,0,0,1),                   // R10 halt
    mk(10, rr(2,0,0,3), 32'hFFFF, 32'hFFFF, 32'd0, 3, 1,0,0,0,1),              // R10 no halt
    mk(11, rr(0,1,2,0), 32'd1, 32'd2, 32'd3, 0, 0,0,0,0,1),                    // R11 r0 dst
    mk(11, ri(0,0,5,16'h0123), 32'hDEADBEEF, 32'd0, 32'h123, 5, 1,0,0,0,1),    // R11 r0 src
    mk(12, rr(7,1,2,3), 32'd1, 32'd1, 32'd0, 3, 0,0,1,0,0),                    // R12
    mk(12, ri(1,1,4,16'h0001), 32'd1, 32'd1, 32'd0, 4, 0,0,1,0,0),             // R12
    mk(12, rr(31,1,2,3), 32'd1, 32'd1, 32'd0, 3, 0,0,1,0,0),                   // R12
    mk(10, ri(2,0,0,16'h0000), 32'd5, 32'd5, 32'd0, 0, 0,0,0,0,1),             // R10 imm form
    mk(1,  ri(3,1,9,16'h5800), 32'd0, 32'd0, 32'h5800, 9, 1,0,0,0,1),          // R1 ri dst
    mk(1,  rr(0,1,2,7), 32'd1, 32'd1, 32'd2, 7, 1,0,0,0,1)                     // R1 rr dst
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0, srcA = '0, srcB = '0;
  logic [4:0]  dstIdx;
  logic        wrEn, haltReq, illegalOp, divZero;
  logic [31:0] result;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dxu_top dut (
    .instr(instr), .srcA(srcA), .srcB(srcB), .dstIdx(dstIdx), .wrEn(wrEn),
    .result(result), .haltReq(haltReq), .illegalOp(illegalOp), .divZero(divZero)
  );

  task automatic check(input int rq, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h instr=%h", rq, what, act, exp, instr);
    end
  endtask

  function automatic bit legalPair(input bit isRR, input int op);
    if (isRR) return (op <= 6) || (op >= 9 && op <= 22);
    return (op == 0) || (op >= 2 && op <= 17) || (op == 20);
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // idle word after reset: add r0,r0,0 writes nothing
    check(11, "idle wrEn", 32'(wrEn), 32'd0);
    check(12, "idle flags", {29'd0, haltReq, illegalOp, divZero}, 32'd0);
    check(2, "idle result", result, 32'd0);

    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      instr = VECS[i].instr; srcA = VECS[i].a; srcB = VECS[i].b;
      @(negedge clk);
      check(int'(VECS[i].req), "dstIdx", 32'(dstIdx), 32'(VECS[i].dst));
      check(int'(VECS[i].req), "wrEn", 32'(wrEn), 32'(VECS[i].wen));
      check(int'(VECS[i].req), "flags h/i/z", {29'd0, haltReq, illegalOp, divZero},
            {29'd0, VECS[i].halt, VECS[i].ill, VECS[i].dz});
      if (VECS[i].chkRes) check(int'(VECS[i].req), "result", result, VECS[i].res);
    end

    // R12 sweep of every opcode in both forms
    for (int f = 0; f < 2; f++) begin
      for (int op = 0; op < 32; op++) begin
        @(posedge clk);
        instr = (f == 1) ? rr(op, 1, 2, 3) : ri(op, 1, 2, 16'h0001);
        srcA = 32'd9; srcB = 32'd1;
        @(negedge clk);
        check(12, "sweep illegalOp", 32'(illegalOp), 32'(!legalPair(f == 1, op)));
        check(12, "sweep wrEn", 32'(wrEn), 32'(legalPair(f == 1, op)));
      end
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule